// File: doc/BRIEF.md
# Two-Port Semaphore Flag Unit

This block gives two processors, a left port and a right port, a bank of eight binary token flags. The flags sit in their own address space, apart from any shared memory. A processor asks for a token by writing a 0 to a flag and gives it back by writing a 1. It then reads the flag to learn whether it holds the token. A flag reads 0 only on the side that owns it. The other side reads 1.

Each flag keeps one request latch per side. A request made by the side that does not own the flag is kept as pending. When the owner gives the token back, the pending side takes it on the next clock edge. If both sides request a free flag in the same cycle, the left side wins and the right request stays pending.

A read captures the flag when it starts and holds that value on all data bits for as long as the read lasts. The whole block is synchronous to one clock and uses an active-high synchronous reset.

Top module: `sema_unit`

## Requirements
- R1: After reset every flag is free: a read of any flag from either side returns all ones. While a side is not reading, its read data is all zeros.
- R2: A side performs a semaphore access only when its `*_sem_n` is 0 and either `*_ce_n` is 1 or both `*_ub_n` and `*_lb_n` are 1. Any other combination has no effect on the flags.
- R3: The flag is selected by address bits 2:0. All higher address bits are ignored.
- R4: A write (`*_we_n` = 0 during an access) uses only data bit 0. A 0 requests the token and a 1 releases it. Data bits 17:1 are ignored.
- R5: When one side requests a free flag, that side owns it from the next cycle. The owner reads all zeros and the other side reads all ones.
- R6: A request of 0 from the side that does not own a flag leaves ownership unchanged. The request is kept as pending.
- R7: When the owner writes 1 while the other side has a request pending, the other side owns the flag from the next cycle.
- R8: When the owner writes 1 with nothing pending, the flag becomes free and both sides read all ones.
- R9: When both sides request the same free flag in the same cycle, the left side gets it and the right request stays pending.
- R10: A read is active during an access with `*_oe_n` = 0 and `*_we_n` = 1. The value is captured on the first active cycle and appears on all 18 data bits from the next cycle. It stays unchanged until the read ends, even if the flag changes in the meantime.
- R11: A write of 1 by a side that does not own the flag withdraws that side's pending request. A later release by the owner then leaves the flag free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_ce_n | input | 1 | Left memory chip enable, active low |
| l_ub_n | input | 1 | Left upper byte enable, active low |
| l_lb_n | input | 1 | Left lower byte enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_we_n | input | 1 | Left write enable, active low |
| l_addr | input | 12 | Left address, bits 2:0 select the flag |
| l_wdata | input | 18 | Left write data, only bit 0 is used |
| l_rdata | output | 18 | Left read data |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_ce_n | input | 1 | Right memory chip enable, active low |
| r_ub_n | input | 1 | Right upper byte enable, active low |
| r_lb_n | input | 1 | Right lower byte enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_we_n | input | 1 | Right write enable, active low |
| r_addr | input | 12 | Right address, bits 2:0 select the flag |
| r_wdata | input | 18 | Right write data, only bit 0 is used |
| r_rdata | output | 18 | Right read data |

## Verification
The bench targets three ownership corner cases:
- **Handover.** The pending side must take the token when the owner releases it. A design without pending latches would leave the flag free instead.
- **Withdrawn request.** Once the pending side writes 1, a later release must leave the flag free. A design that keeps a stale request would hand the token to a side that no longer wants it.
- **Same-cycle tie.** Both sides request a free flag in the same cycle. A broken tie-break would grant the flag to both sides or to the right side.

The bench also checks the access and read rules:
- **Held read.** A read in progress across a handover must keep its old value. A read path without the hold would switch mid-read.
- **Access decoding.** Writes made with memory access decoding must be ignored, and high address bits must not change which flag is selected.

// File: rtl/sema_pkg.sv
package sema_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        logic wr;
        logic val;
    } sema_cmd_t;

    // New owner from the current owner and the updated request latches
    // (latch value 0 means "requesting"). The current owner keeps the flag
    // while its own latch stays 0; on a tie from free the left side wins.
    function automatic owner_e next_owner(owner_e cur, logic nreq_l, logic nreq_r);
        owner_e nxt;
        unique case (cur)
            OWN_RIGHT: nxt = !nreq_r ? OWN_RIGHT : (!nreq_l ? OWN_LEFT : OWN_NONE);
            OWN_LEFT:  nxt = !nreq_l ? OWN_LEFT  : (!nreq_r ? OWN_RIGHT : OWN_NONE);
            default:   nxt = !nreq_l ? OWN_LEFT  : (!nreq_r ? OWN_RIGHT : OWN_NONE);
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/sema_port_decode.sv
module sema_port_decode
    import sema_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 18,
    parameter int IDX_W  = 3
) (
    input  logic              sem_n,
    input  logic              ce_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [IDX_W-1:0]  idx,
    output sema_cmd_t         cmd,
    output logic              rd_act
);
    logic access;
    logic unused_bits;

    assign access      = !sem_n && (ce_n || (ub_n && lb_n));
    assign idx         = addr[IDX_W-1:0];
    assign cmd.wr      = access && !we_n;
    assign cmd.val     = wdata[0];
    assign rd_act      = access && !oe_n && we_n;
    assign unused_bits = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};
endmodule

// File: rtl/sema_flag_cell.sv
module sema_flag_cell
    import sema_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hit_l,
    input  logic val_l,
    input  logic hit_r,
    input  logic val_r,
    output logic own_l,
    output logic own_r
);
    logic   req_l_q, req_r_q;
    owner_e owner_q;
    logic   nreq_l, nreq_r;

    assign nreq_l = hit_l ? val_l : req_l_q;
    assign nreq_r = hit_r ? val_r : req_r_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_l_q <= 1'b1;
            req_r_q <= 1'b1;
            owner_q <= OWN_NONE;
        end else begin
            req_l_q <= nreq_l;
            req_r_q <= nreq_r;
            owner_q <= next_owner(owner_q, nreq_l, nreq_r);
        end
    end

    assign own_l = (owner_q == OWN_LEFT);
    assign own_r = (owner_q == OWN_RIGHT);
endmodule

// File: rtl/sema_read_hold.sv
module sema_read_hold #(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_act,
    input  logic              view,
    output logic [DATA_W-1:0] rdata
);
    logic act_q;
    logic hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            hold_q <= 1'b1;
        end else begin
            act_q <= rd_act;
            if (rd_act && !act_q) begin
                hold_q <= view;
            end
        end
    end

    assign rdata = act_q ? {DATA_W{hold_q}} : '0;
endmodule

// File: rtl/sema_unit.sv
module sema_unit
    import sema_pkg::*;
#(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sem_n,
    input  logic              l_ce_n,
    input  logic              l_ub_n,
    input  logic              l_lb_n,
    input  logic              l_oe_n,
    input  logic              l_we_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sem_n,
    input  logic              r_ce_n,
    input  logic              r_ub_n,
    input  logic              r_lb_n,
    input  logic              r_oe_n,
    input  logic              r_we_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    localparam int IDX_W = $clog2(NUM_FLAGS);

    logic [IDX_W-1:0]     l_idx, r_idx;
    sema_cmd_t            l_cmd, r_cmd;
    logic                 l_rd_act, r_rd_act;
    logic [NUM_FLAGS-1:0] own_l_vec, own_r_vec;

    sema_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) l_dec_i (
        .sem_n(l_sem_n), .ce_n(l_ce_n), .ub_n(l_ub_n), .lb_n(l_lb_n),
        .oe_n(l_oe_n), .we_n(l_we_n), .addr(l_addr), .wdata(l_wdata),
        .idx(l_idx), .cmd(l_cmd), .rd_act(l_rd_act)
    );

    sema_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) r_dec_i (
        .sem_n(r_sem_n), .ce_n(r_ce_n), .ub_n(r_ub_n), .lb_n(r_lb_n),
        .oe_n(r_oe_n), .we_n(r_we_n), .addr(r_addr), .wdata(r_wdata),
        .idx(r_idx), .cmd(r_cmd), .rd_act(r_rd_act)
    );

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
        sema_flag_cell cell_i (
            .clk  (clk),
            .rst  (rst),
            .hit_l(l_cmd.wr && (l_idx == IDX_W'(k))),
            .val_l(l_cmd.val),
            .hit_r(r_cmd.wr && (r_idx == IDX_W'(k))),
            .val_r(r_cmd.val),
            .own_l(own_l_vec[k]),
            .own_r(own_r_vec[k])
        );
    end

    sema_read_hold #(.DATA_W(DATA_W)) l_hold_i (
        .clk(clk), .rst(rst), .rd_act(l_rd_act),
        .view(!own_l_vec[l_idx]), .rdata(l_rdata)
    );

    sema_read_hold #(.DATA_W(DATA_W)) r_hold_i (
        .clk(clk), .rst(rst), .rd_act(r_rd_act),
        .view(!own_r_vec[r_idx]), .rdata(r_rdata)
    );
endmodule

// File: rtl/sema_unit_chk.sv
module sema_unit_chk #(
    parameter int NUM_FLAGS = 8,
    parameter int DATA_W    = 18,
    parameter int IDX_W     = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 l_wr,
    input logic                 l_val,
    input logic [IDX_W-1:0]     l_idx,
    input logic                 r_wr,
    input logic                 r_val,
    input logic [IDX_W-1:0]     r_idx,
    input logic                 l_rd_act,
    input logic                 r_rd_act,
    input logic [NUM_FLAGS-1:0] own_l_vec,
    input logic [NUM_FLAGS-1:0] own_r_vec,
    input logic [DATA_W-1:0]    l_rdata,
    input logic [DATA_W-1:0]    r_rdata
);
    // R5 R9
    left_grant_free_chk: assert property (@(posedge clk) disable iff (rst)
        (l_wr && !l_val && !own_l_vec[l_idx] && !own_r_vec[l_idx])
        |=> own_l_vec[$past(l_idx)]);

    // R6
    right_no_steal_chk: assert property (@(posedge clk) disable iff (rst)
        (r_wr && !r_val && own_l_vec[r_idx] && !(l_wr && l_val && l_idx == r_idx))
        |=> !own_r_vec[$past(r_idx)]);

    // R10
    left_read_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (l_rd_act && $past(l_rd_act)) |=> $stable(l_rdata));

    // R10
    right_read_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (r_rd_act && $past(r_rd_act)) |=> $stable(r_rdata));

    // R10
    read_replicated_chk: assert property (@(posedge clk) disable iff (rst)
        (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_own
        // R7 R8
        left_release_only_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(own_l_vec[k]) |-> $past(l_wr && l_val && l_idx == IDX_W'(k)));
        // R7 R8
        right_release_only_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(own_r_vec[k]) |-> $past(r_wr && r_val && r_idx == IDX_W'(k)));
    end
endmodule

bind sema_unit sema_unit_chk #(
    .NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W), .IDX_W(IDX_W)
) chk_i (
    .clk(clk), .rst(rst),
    .l_wr(l_cmd.wr), .l_val(l_cmd.val), .l_idx(l_idx),
    .r_wr(r_cmd.wr), .r_val(r_cmd.val), .r_idx(r_idx),
    .l_rd_act(l_rd_act), .r_rd_act(r_rd_act),
    .own_l_vec(own_l_vec), .own_r_vec(own_r_vec),
    .l_rdata(l_rdata), .r_rdata(r_rdata)
);

// File: tb/sema_unit_tb.sv
module sema_unit_tb_top;
    localparam logic [17:0] ONES = 18'h3FFFF;
    localparam logic [17:0] REQ_D = 18'h3FFFE;  // bit0 = 0, others 1
    localparam logic [17:0] REL_D = 18'h00001;  // bit0 = 1, others 0
    localparam int NV = 14;
    // {op_l[1:0], op_r[1:0], idx[2:0], exp_l, exp_r}; op: 0 none, 1 request, 2 release
    localparam logic [8:0] VEC [NV] = '{
        9'b01_00_011_0_1,  // R5 left acquires
        9'b00_01_011_0_1,  // R6 right pending
        9'b10_00_011_1_0,  // R7 handover to right
        9'b01_00_011_1_0,  // R6 left pending
        9'b00_10_011_0_1,  // R7 handover to left
        9'b10_00_011_1_1,  // R8 free
        9'b01_01_011_0_1,  // R9 tie to left
        9'b10_00_011_1_0,  // R7 right pending takes over
        9'b00_10_011_1_1,  // R8 free
        9'b00_01_011_1_0,  // R5 right acquires
        9'b01_00_011_1_0,  // R6 left pending
        9'b10_00_011_1_0,  // R11 left withdraws
        9'b00_10_011_1_1,  // R11 release leaves free
        9'b00_01_101_1_0   // R5 other flag
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        l_sem_n, l_ce_n, l_ub_n, l_lb_n, l_oe_n, l_we_n;
    logic [11:0] l_addr;
    logic [17:0] l_wdata, l_rdata;
    logic        r_sem_n, r_ce_n, r_ub_n, r_lb_n, r_oe_n, r_we_n;
    logic [11:0] r_addr;
    logic [17:0] r_wdata, r_rdata;
    int checks = 0;
    int failures = 0;
    logic [17:0] vl, vr;

    always #10 clk = ~clk;

    sema_unit dut_i (
        .clk(clk), .rst(rst),
        .l_sem_n(l_sem_n), .l_ce_n(l_ce_n), .l_ub_n(l_ub_n), .l_lb_n(l_lb_n),
        .l_oe_n(l_oe_n), .l_we_n(l_we_n), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata),
        .r_sem_n(r_sem_n), .r_ce_n(r_ce_n), .r_ub_n(r_ub_n), .r_lb_n(r_lb_n),
        .r_oe_n(r_oe_n), .r_we_n(r_we_n), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata)
    );

    task automatic idle_l();
        l_sem_n = 1; l_ce_n = 1; l_ub_n = 1; l_lb_n = 1; l_oe_n = 1; l_we_n = 1;
        l_addr = '0; l_wdata = '0;
    endtask

    task automatic idle_r();
        r_sem_n = 1; r_ce_n = 1; r_ub_n = 1; r_lb_n = 1; r_oe_n = 1; r_we_n = 1;
        r_addr = '0; r_wdata = '0;
    endtask

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one write cycle on either or both sides
    task automatic wr_cycle(input logic [1:0] opl, input logic [11:0] al,
                            input logic [1:0] opr, input logic [11:0] ar);
        @(negedge clk);
        if (opl != 0) begin
            l_sem_n = 0; l_we_n = 0; l_addr = al;
            l_wdata = (opl == 1) ? REQ_D : REL_D;
        end
        if (opr != 0) begin
            r_sem_n = 0; r_we_n = 0; r_addr = ar;
            r_wdata = (opr == 1) ? REQ_D : REL_D;
        end
        @(negedge clk);
        idle_l(); idle_r();
    endtask

    task automatic read_both(input logic [11:0] a, output logic [17:0] ol, output logic [17:0] orr);
        @(negedge clk);
        l_sem_n = 0; l_oe_n = 0; l_addr = a;
        r_sem_n = 0; r_oe_n = 0; r_addr = a;
        @(negedge clk);
        ol = l_rdata; orr = r_rdata;
        idle_l(); idle_r();
        @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle_l(); idle_r();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 idle read data zero, all flags free
        check("R1 idle left", l_rdata, '0);
        check("R1 idle right", r_rdata, '0);
        read_both(12'h000, vl, vr);
        check("R1 left flag0", vl, ONES);
        check("R1 right flag0", vr, ONES);
        read_both(12'h007, vl, vr);
        check("R1 left flag7", vl, ONES);

        // table walk, high address bits set to exercise R3
        for (int i = 0; i < NV; i++) begin
            logic [11:0] a;
            a = {9'h155, VEC[i][4:2]};
            wr_cycle(VEC[i][8:7], a, VEC[i][6:5], a);
            read_both({9'h0AA, VEC[i][4:2]}, vl, vr);
            check($sformatf("R5-vec%0d left", i), vl, {18{VEC[i][1]}});
            check($sformatf("R5-vec%0d right", i), vr, {18{VEC[i][0]}});
        end
        wr_cycle(2'd0, 12'h0, 2'd2, 12'h005);

        // R3 high address bits ignored; R4 only bit 0 used
        wr_cycle(2'd1, 12'hFF9, 2'd0, 12'h0);
        read_both(12'h001, vl, vr);
        check("R3 left owns flag1", vl, '0);
        check("R4 right sees flag1 taken", vr, ONES);
        read_both(12'h000, vl, vr);
        check("R3 flag0 untouched", vl, ONES);
        wr_cycle(2'd2, 12'h801, 2'd0, 12'h0);
        read_both(12'h001, vl, vr);
        check("R4 release via bit0", vl, ONES);

        // R2 memory access decoding must not touch flags
        @(negedge clk);
        l_sem_n = 0; l_ce_n = 0; l_ub_n = 0; l_lb_n = 1; l_we_n = 0;
        l_addr = 12'h004; l_wdata = REQ_D;
        @(negedge clk);
        idle_l();
        read_both(12'h004, vl, vr);
        check("R2 ignored with memory select", vl, ONES);
        @(negedge clk);
        l_sem_n = 0; l_ce_n = 0; l_ub_n = 1; l_lb_n = 1; l_we_n = 0;
        l_addr = 12'h004; l_wdata = REQ_D;
        @(negedge clk);
        idle_l();
        read_both(12'h004, vl, vr);
        check("R2 bytes off counts as access", vl, '0);
        wr_cycle(2'd2, 12'h004, 2'd0, 12'h0);

        // R10 read held across a handover
        wr_cycle(2'd1, 12'h002, 2'd0, 12'h0);
        wr_cycle(2'd0, 12'h0, 2'd1, 12'h002);
        @(negedge clk);
        r_sem_n = 0; r_oe_n = 0; r_addr = 12'h002;
        @(negedge clk);
        check("R10 start value", r_rdata, ONES);
        l_sem_n = 0; l_we_n = 0; l_addr = 12'h002; l_wdata = REL_D;
        @(negedge clk);
        idle_l();
        check("R10 held after handover", r_rdata, ONES);
        @(negedge clk);
        check("R10 still held", r_rdata, ONES);
        idle_r();
        @(negedge clk);
        check("R10 idle zero after read", r_rdata, '0);
        read_both(12'h002, vl, vr);
        check("R10 fresh read shows ownership", vr, '0);
        check("R7 left lost flag2", vl, ONES);
        wr_cycle(2'd0, 12'h0, 2'd2, 12'h002);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule